// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block sits in the decode stage of a five-stage in-order pipeline. It picks the two source operands, A and B, that decode passes on to execute. For each operand it compares the decode source register ID against the destination IDs of the instructions that are further down the pipeline. When there is a match, it takes the newer value directly from the producing stage, so decode does not have to wait for that value to reach the register file.

Each operand can come from six candidates: the ALU result being computed this cycle in execute, the two results held in the memory stage, the two results held in write-back, and the register-file read data. The youngest producer always wins. Operand A has one more case: call and jump instructions need the incremented PC carried in that slot, and that case overrides all forwarding.

The block is purely combinational. It has no clock, no reset and no state. The register file, the pipeline registers and the stall control are outside it.

Top module: `fwd_select`

## Requirements
- R1: When the decode instruction code is a jump (default code 4'h7) or a call (default code 4'h8), `op_a` equals `dec_pc_next`, whatever the stage destinations hold.
- R2: Otherwise, if the source ID equals `exe_dst_e`, the operand is `exe_alu`. This candidate beats every other stage.
- R3: Failing R2, a match with `mem_dst_m` selects `mem_rd`.
- R4: Failing R2 and R3, a match with `mem_dst_e` selects `mem_val_e`.
- R5: Failing R2 to R4, a match with `wb_dst_m` selects `wb_val_m`.
- R6: Failing R2 to R5, a match with `wb_dst_e` selects `wb_val_e`.
- R7: If no stage destination matches, the operand is the register-file data (`rf_a` or `rf_b`).
- R8: The ID with all bits set (4'hF by default) means "no register". A source of that value never forwards, even when a destination also holds that value; the operand is then the register-file data.
- R9: Operand B follows R2 to R8 with `src_b` and `rf_b`. The instruction code and `dec_pc_next` have no effect on it.
- R10: The outputs follow the inputs within the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_icode | input | 4 | Instruction code in decode |
| dec_pc_next | input | 32 | Incremented PC of the decode instruction |
| src_a | input | 4 | Source register ID for operand A |
| src_b | input | 4 | Source register ID for operand B |
| rf_a | input | 32 | Register-file read data for A |
| rf_b | input | 32 | Register-file read data for B |
| exe_dst_e | input | 4 | Execute-stage ALU destination |
| exe_alu | input | 32 | ALU result computed this cycle |
| mem_dst_e | input | 4 | Memory-stage ALU destination |
| mem_val_e | input | 32 | Memory-stage ALU result |
| mem_dst_m | input | 4 | Memory-stage load destination |
| mem_rd | input | 32 | Data read from memory this cycle |
| wb_dst_e | input | 4 | Write-back ALU destination |
| wb_val_e | input | 32 | Write-back ALU result |
| wb_dst_m | input | 4 | Write-back load destination |
| wb_val_m | input | 32 | Write-back loaded value |
| op_a | output | 32 | Selected operand A |
| op_b | output | 32 | Selected operand B |

## Verification
The assertions assume the inputs are settled, two-state values whenever the block evaluates. They also assume that all destination fields are meaningful at once, even when the same register appears in several stages. The stimulus changes all inputs together at one point in each clock period and reads the outputs after a short delay, so no check sees a half-updated set of tags. The destinations are drawn from a small pool of IDs that includes the "no register" value, so overlapping matches and "no register" sources occur often.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int RW = 4,
  parameter int DW = 32,
  parameter logic [3:0] JUMP_CODE = 4'h7,
  parameter logic [3:0] CALL_CODE = 4'h8
) (
  input  logic [3:0]    dec_icode,
  input  logic [DW-1:0] dec_pc_next,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [RW-1:0] exe_dst_e,
  input  logic [DW-1:0] exe_alu,
  input  logic [RW-1:0] mem_dst_e,
  input  logic [DW-1:0] mem_val_e,
  input  logic [RW-1:0] mem_dst_m,
  input  logic [DW-1:0] mem_rd,
  input  logic [RW-1:0] wb_dst_e,
  input  logic [DW-1:0] wb_val_e,
  input  logic [RW-1:0] wb_dst_m,
  input  logic [DW-1:0] wb_val_m,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b
);
  localparam logic [RW-1:0] NONE_ID = {RW{1'b1}};

  function automatic logic hit(input logic [RW-1:0] s, input logic [RW-1:0] d);
    return (s != NONE_ID) && (s == d);
  endfunction

  function automatic logic [DW-1:0] chain(input logic [RW-1:0] s, input logic [DW-1:0] rf);
    if      (hit(s, exe_dst_e)) return exe_alu;
    else if (hit(s, mem_dst_m)) return mem_rd;
    else if (hit(s, mem_dst_e)) return mem_val_e;
    else if (hit(s, wb_dst_m))  return wb_val_m;
    else if (hit(s, wb_dst_e))  return wb_val_e;
    else                        return rf;
  endfunction

  logic link;
  assign link = (dec_icode == JUMP_CODE) || (dec_icode == CALL_CODE);

  always_comb begin
    op_a = link ? dec_pc_next : chain(src_a, rf_a);
    op_b = chain(src_b, rf_b);

    if (link)
      a_r1_pc_override: assert (op_a == dec_pc_next);
    if (!link && hit(src_a, exe_dst_e))
      a_r2_exe_first: assert (op_a == exe_alu);
    if (src_b == NONE_ID)
      a_r8_none_no_fwd: assert (op_b == rf_b);
    if (hit(src_b, exe_dst_e))
      a_r9_b_no_pc: assert (op_b == exe_alu);
    if (src_b != exe_dst_e && src_b != mem_dst_e && src_b != mem_dst_m &&
        src_b != wb_dst_e && src_b != wb_dst_m)
      a_r7_rf_default: assert (op_b == rf_b);
  end
endmodule

// File: tb/sim_fwd_select.sv
module sim_fwd_select;
  localparam logic [3:0] NONE = 4'hF;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [3:0]  dec_icode, src_a, src_b;
  logic [3:0]  exe_dst_e, mem_dst_e, mem_dst_m, wb_dst_e, wb_dst_m;
  logic [31:0] dec_pc_next, rf_a, rf_b, exe_alu, mem_val_e, mem_rd, wb_val_e, wb_val_m;
  logic [31:0] op_a, op_b;
  int errs = 0, checks = 0;

  fwd_select u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic base();
    @(posedge clk);
    dec_icode = 4'h2; dec_pc_next = 32'h0000_0A00;
    rf_a = 32'hAAAA_0000; rf_b = 32'hBBBB_0000;
    exe_alu = 32'h1111_1111; mem_rd = 32'h2222_2222; mem_val_e = 32'h3333_3333;
    wb_val_m = 32'h4444_4444; wb_val_e = 32'h5555_5555;
    exe_dst_e = NONE; mem_dst_m = NONE; mem_dst_e = NONE; wb_dst_m = NONE; wb_dst_e = NONE;
    src_a = 4'h1; src_b = 4'h2;
  endtask

  task automatic t_reset_state();
    base(); #2;
    chk("R7 idle A", op_a, 32'hAAAA_0000);
    chk("R7 idle B", op_b, 32'hBBBB_0000);
  endtask

  task automatic t_priority();
    base();
    exe_dst_e = 1; mem_dst_m = 1; mem_dst_e = 1; wb_dst_m = 1; wb_dst_e = 1;
    exe_dst_e = 1; #2; chk("R2 exe over all", op_a, 32'h1111_1111);
    exe_dst_e = 3; #2; chk("R3 mem load next", op_a, 32'h2222_2222);
    mem_dst_m = 3; #2; chk("R4 mem alu next", op_a, 32'h3333_3333);
    mem_dst_e = 3; #2; chk("R5 wb load next", op_a, 32'h4444_4444);
    wb_dst_m = 3;  #2; chk("R6 wb alu last", op_a, 32'h5555_5555);
    wb_dst_e = 3;  #2; chk("R7 rf fallback", op_a, 32'hAAAA_0000);
  endtask

  task automatic t_link();
    base();
    exe_dst_e = 1; mem_dst_m = 2;
    dec_icode = 4'h7; #2;
    chk("R1 jump override", op_a, 32'h0000_0A00);
    chk("R9 B unaffected by jump", op_b, 32'h2222_2222);
    dec_icode = 4'h8; #2;
    chk("R1 call override", op_a, 32'h0000_0A00);
    dec_icode = 4'h6; #2;
    chk("R1 other code forwards", op_a, 32'h1111_1111);
  endtask

  task automatic t_none();
    base();
    src_a = NONE; src_b = NONE;
    exe_dst_e = NONE; mem_dst_m = NONE; wb_dst_e = NONE; #2;
    chk("R8 none A", op_a, 32'hAAAA_0000);
    chk("R8 none B", op_b, 32'hBBBB_0000);
  endtask

  task automatic t_b_chain();
    base();
    src_b = 4'h5; wb_dst_e = 5; wb_dst_m = 5; #2;
    chk("R9 B wb load over wb alu", op_b, 32'h4444_4444);
    mem_dst_e = 5; #2;
    chk("R9 B mem alu", op_b, 32'h3333_3333);
  endtask

  task automatic t_same_cycle();
    base();
    exe_dst_e = 1; #1;
    chk("R10 immediate", op_a, 32'h1111_1111);
    exe_alu = 32'hDEAD_BEEF; #1;
    chk("R10 follows alu", op_a, 32'hDEAD_BEEF);
  endtask

  function automatic logic [31:0] model(input logic [3:0] s, input logic [31:0] rf);
    logic [3:0]  d[5];
    logic [31:0] v[5];
    d = '{exe_dst_e, mem_dst_m, mem_dst_e, wb_dst_m, wb_dst_e};
    v = '{exe_alu, mem_rd, mem_val_e, wb_val_m, wb_val_e};
    if (s == NONE) return rf;
    for (int k = 0; k < 5; k++) if (d[k] == s) return v[k];
    return rf;
  endfunction

  task automatic t_random();
    logic [3:0] pool[4] = '{4'h1, 4'h2, 4'h3, NONE};
    for (int n = 0; n < 300; n++) begin
      @(posedge clk);
      dec_icode = 4'($urandom_range(5, 9));
      dec_pc_next = $urandom; rf_a = $urandom; rf_b = $urandom;
      exe_alu = $urandom; mem_rd = $urandom; mem_val_e = $urandom;
      wb_val_m = $urandom; wb_val_e = $urandom;
      src_a = pool[$urandom_range(0, 3)]; src_b = pool[$urandom_range(0, 3)];
      exe_dst_e = pool[$urandom_range(0, 3)]; mem_dst_m = pool[$urandom_range(0, 3)];
      mem_dst_e = pool[$urandom_range(0, 3)]; wb_dst_m = pool[$urandom_range(0, 3)];
      wb_dst_e = pool[$urandom_range(0, 3)];
      #2;
      chk("R2-chain random A", op_a,
          (dec_icode == 4'h7 || dec_icode == 4'h8) ? dec_pc_next : model(src_a, rf_a));
      chk("R9 random B", op_b, model(src_b, rf_b));
    end
  endtask

  initial begin
    fork
      begin
        t_reset_state(); t_priority(); t_link(); t_none();
        t_b_chain(); t_same_cycle(); t_random();
      end
      begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule